// File: doc/BRIEF.md
# SPI Flash Status-Register Write Guard

This block sits on the slave side of an SPI serial flash. It decodes the instruction frames that change the protection status register, and it enforces the hardware write-protect rules on that register. Instruction and data bits arrive on the serial input while chip select is low. They are sampled on rising serial-clock edges, most significant bit first, and both idle-low (mode 0) and idle-high (mode 3) clocks are accepted. The block samples the serial pins with the system clock through a synchronizer, so the system clock must run several times faster than the serial clock.

Changing the status register takes two frames. The first is an 8-bit arming frame, opcode 0x50 or 0x06. The second must follow it directly: a 16-bit frame with opcode 0x01 and then one data byte. Every instruction executes when chip select rises at the end of its frame. A lock bit, together with the active-low write-protect pin, decides whether the write lands. While the pin is low, a set lock bit freezes the whole register. While the pin is high, the lock has no effect. The register value is always visible on a parallel readback port.

Top module: `sr_guard`

## Requirements
- R1: After reset the status readback is 0x3C: lock bit (bit 7) is 0, block-protect bits 5..2 are all 1, and the arm state is clear. A write-status frame sent first after reset leaves the register unchanged.
- R2: An 8-bit frame carrying 0x50 or 0x06 arms the register. A 16-bit frame sent directly after it, holding opcode 0x01 and then a data byte, loads the register when chip select rises.
- R3: A write-status frame has no effect unless the frame just before it was an arming frame. Any other instruction in between cancels the arm, and one arm permits only one write.
- R4: A frame whose bit count is wrong is discarded and clears the arm state. The arming opcodes need exactly 8 bits and the write-status opcode exactly 16.
- R5: Only bit 7 (lock) and bits 5..2 (block protect, bit 5 is the highest) take the data byte. Bits 6, 1 and 0 always read 0.
- R6: If write-protect is low and the lock bit is 1 when the frame ends, the write-status instruction is ignored entirely.
- R7: If write-protect is low and the lock bit is 0, one write-status instruction may set the lock bit and change the block-protect bits together. Once set, the lock bit cannot be cleared while write-protect stays low.
- R8: If write-protect is high, every writable bit can change, and that includes clearing the lock bit.
- R9: Frames are decoded the same way with an idle-low (mode 0) or idle-high (mode 3) serial clock. Bits are taken on rising clock edges, MSB first.
- R10: The status register never changes during a frame. It changes only after chip select rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock; serial pins are oversampled with it |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sck_i | input | 1 | Serial clock from the host |
| cs_ni | input | 1 | Active-low chip select; a rising edge ends a frame |
| si_i | input | 1 | Serial data input, MSB first |
| wp_ni | input | 1 | Active-low hardware write-protect |
| status_o | output | 8 | Current status register value |

## Verification
The arm flag cannot be seen at the ports. If it is held wrongly, the fault shows on the readback one frame later, after the next write-status frame either lands or is dropped. The sequences therefore pair every cancelling frame with a write whose data differs from the current value. A bad bit counter or a bad opcode capture shows at the first chip-select rise that ends a frame. A lock rule that fails shows at once, because each protected write uses data that would visibly change the register. Between frames, the readback is compared with the reference every system clock.

// File: rtl/sr_guard_pkg.sv
package sr_guard_pkg;
  localparam int unsigned BYTE_W = 8;

  localparam logic [BYTE_W-1:0] OP_ARM_SR = 8'h50;
  localparam logic [BYTE_W-1:0] OP_ARM_WR = 8'h06;
  localparam logic [BYTE_W-1:0] OP_WR_SR  = 8'h01;

  localparam int unsigned LOCK_BIT = 7;
  // writable: lock (7) and block protect (5..2)
  localparam logic [BYTE_W-1:0] SR_WMASK = 8'hBC;
  localparam logic [BYTE_W-1:0] SR_RESET = 8'h3C;

  typedef enum logic [1:0] {
    FR_ARM   = 2'd0,
    FR_WRITE = 2'd1,
    FR_OTHER = 2'd2
  } frame_kind_e;
endpackage

// File: rtl/sr_guard_sync.sv
module sr_guard_sync #(
  parameter int unsigned W = 4,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= {STAGES{RST_VAL}};
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/sr_guard_shift.sv
module sr_guard_shift
  import sr_guard_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_n_i,
  input  logic              sck_i,
  input  logic              si_i,
  output logic              frame_end_o,
  output frame_kind_e       kind_o,
  output logic [BYTE_W-1:0] data_o
);
  localparam int unsigned CNT_MAX = 2 * BYTE_W + 1;
  localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] CNT_OP   = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(2 * BYTE_W);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(CNT_MAX);

  logic              sck_q, cs_q;
  logic              sck_rise, cs_fall, cs_rise;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0] sr_q, op_q, sr_next;

  assign sck_rise = sck_i & ~sck_q & ~cs_n_i;
  assign cs_fall  = ~cs_n_i & cs_q;
  assign cs_rise  = cs_n_i & ~cs_q;
  assign sr_next  = {sr_q[BYTE_W-2:0], si_i};

  always_comb begin
    cnt_d = cs_fall ? '0 : cnt_q;
    if (sck_rise && cnt_d != CNT_SAT) cnt_d = cnt_d + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q <= 1'b0;
      cs_q  <= 1'b1;
      cnt_q <= '0;
      sr_q  <= '0;
      op_q  <= '0;
    end else begin
      sck_q <= sck_i;
      cs_q  <= cs_n_i;
      cnt_q <= cnt_d;
      if (sck_rise) begin
        sr_q <= sr_next;
        if (cnt_d == CNT_OP) op_q <= sr_next;
      end
    end
  end

  always_comb begin
    kind_o = FR_OTHER;
    if (cnt_q == CNT_OP && (op_q == OP_ARM_SR || op_q == OP_ARM_WR)) kind_o = FR_ARM;
    else if (cnt_q == CNT_FULL && op_q == OP_WR_SR)                  kind_o = FR_WRITE;
  end

  assign frame_end_o = cs_rise;
  assign data_o      = sr_q;

  a_r4_cnt_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_SAT);
  a_r10_cnt_idle_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_i |=> $stable(cnt_q));
endmodule

// File: rtl/sr_guard_ctrl.sv
module sr_guard_ctrl
  import sr_guard_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_end_i,
  input  frame_kind_e       kind_i,
  input  logic [BYTE_W-1:0] data_i,
  input  logic              wp_n_i,
  output logic [BYTE_W-1:0] status_o
);
  logic              arm_q;
  logic [BYTE_W-1:0] sr_q;
  logic              blocked;

  assign blocked = ~wp_n_i & sr_q[LOCK_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      arm_q <= 1'b0;
      sr_q  <= SR_RESET;
    end else if (frame_end_i) begin
      arm_q <= (kind_i == FR_ARM);
      if (kind_i == FR_WRITE && arm_q && !blocked) sr_q <= data_i & SR_WMASK;
    end
  end

  assign status_o = sr_q;

  a_r3_no_write_unarmed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !arm_q |=> $stable(sr_q));
  a_r4_bad_frame_disarms: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_end_i && kind_i != FR_ARM) |=> !arm_q);
  a_r6_locked_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_end_i && !wp_n_i && sr_q[LOCK_BIT]) |=> $stable(sr_q));
  a_r7_lock_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sr_q[LOCK_BIT] && !wp_n_i) |=> sr_q[LOCK_BIT]);
  a_r10_change_at_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_end_i |=> $stable(sr_q));
  a_r5_ro_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sr_q & ~SR_WMASK) == '0);
endmodule

// File: rtl/sr_guard.sv
module sr_guard
  import sr_guard_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sck_i,
  input  logic              cs_ni,
  input  logic              si_i,
  input  logic              wp_ni,
  output logic [BYTE_W-1:0] status_o
);
  // bit order {wp_n, si, sck, cs_n}
  localparam logic [3:0] PIN_RST = 4'b1001;

  logic [3:0]        pins_s;
  logic              frame_end;
  frame_kind_e       kind;
  logic [BYTE_W-1:0] data;

  sr_guard_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(PIN_RST)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({wp_ni, si_i, sck_i, cs_ni}),
    .q_o   (pins_s)
  );

  sr_guard_shift u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cs_n_i     (pins_s[0]),
    .sck_i      (pins_s[1]),
    .si_i       (pins_s[2]),
    .frame_end_o(frame_end),
    .kind_o     (kind),
    .data_o     (data)
  );

  sr_guard_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .frame_end_i(frame_end),
    .kind_i     (kind),
    .data_i     (data),
    .wp_n_i     (pins_s[3]),
    .status_o   (status_o)
  );
endmodule

// File: tb/sr_guard_bench.sv
module sr_guard_bench;
  localparam int HALF = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sck = 1'b0, cs_n = 1'b1, si = 1'b0, wp_n = 1'b1;
  logic [7:0] status;

  logic [7:0] model = 8'h3C;
  bit         armed = 1'b0;
  bit         cmp_en = 1'b0;
  bit         done = 1'b0;
  int         tests = 0, fails = 0;

  always #10 clk = ~clk;

  sr_guard u_sr_guard (
    .clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .cs_ni(cs_n),
    .si_i(si), .wp_ni(wp_n), .status_o(status)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: status actual %h expected %h", req, act, exp);
    end
  endtask

  // per-clock comparison against the reference between frame ends
  always @(negedge clk) if (rst_n && cmp_en && !done) chk("R10", status, model);

  task automatic frame(input logic [15:0] v, input int n, input bit m3);
    logic [7:0] op, dat;
    op  = (n == 16) ? v[15:8] : v[7:0];
    dat = v[7:0];
    sck = m3;
    repeat (HALF) @(negedge clk);
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      sck = 1'b0; si = v[n-1-i];
      repeat (HALF) @(negedge clk);
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
    end
    if (!m3) sck = 1'b0;
    repeat (HALF) @(negedge clk);
    chk("R10", status, model);  // no change before chip select rises
    if (n == 8 && (op == 8'h50 || op == 8'h06)) armed = 1'b1;
    else begin
      if (n == 16 && op == 8'h01 && armed && !(wp_n == 1'b0 && model[7]))
        model = dat & 8'hBC;
      armed = 1'b0;
    end
    cmp_en = 1'b0;
    cs_n = 1'b1;
    repeat (8) @(negedge clk);
    cmp_en = 1'b1;
  endtask

  task automatic set_wp(input logic v);
    wp_n = v;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", status, 8'h3C);
    cmp_en = 1'b1;

    frame(16'h0100, 16, 0);           chk("R1", status, 8'h3C);
    frame(16'h0050, 8, 0);  frame(16'h0147, 16, 0); chk("R5", status, 8'h04);
    frame(16'h0006, 8, 0);  frame(16'h01FF, 16, 0); chk("R2", status, 8'hBC);
    frame(16'h0006, 8, 0);  frame(16'h0100, 16, 0); chk("R8", status, 8'h00);
    frame(16'h013C, 16, 0);                          chk("R3", status, 8'h00);
    frame(16'h0006, 8, 0);  frame(16'h0005, 8, 0); frame(16'h0118, 16, 0);
    chk("R3", status, 8'h00);
    frame(16'h000C, 9, 0);  frame(16'h0118, 16, 0); chk("R4", status, 8'h00);
    frame(16'h0006, 8, 0);  frame(16'h008C, 15, 0); frame(16'h0118, 16, 0);
    chk("R4", status, 8'h00);
    frame(16'h0650, 16, 0); frame(16'h0118, 16, 0); chk("R4", status, 8'h00);
    frame(16'h0001, 8, 0);  chk("R4", status, 8'h00);
    frame(16'h0006, 8, 1);  frame(16'h0128, 16, 1); chk("R9", status, 8'h28);
    frame(16'h0050, 8, 1);  frame(16'h0114, 16, 0); chk("R9", status, 8'h14);
    set_wp(1'b0);
    frame(16'h0050, 8, 0);  frame(16'h0120, 16, 0); chk("R7", status, 8'h20);
    frame(16'h0006, 8, 0);  frame(16'h0198, 16, 0); chk("R7", status, 8'h98);
    frame(16'h0050, 8, 0);  frame(16'h0100, 16, 0); chk("R6", status, 8'h98);
    frame(16'h0006, 8, 1);  frame(16'h0184, 16, 1); chk("R6", status, 8'h98);
    set_wp(1'b1);
    frame(16'h0050, 8, 0);  frame(16'h013C, 16, 0); chk("R8", status, 8'h3C);
    frame(16'h0006, 8, 0);  frame(16'h01C3, 16, 0); chk("R5", status, 8'h80);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      tests++; fails++;
      $display("FAIL watchdog: run actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule